// File: doc/BRIEF.md
# Adaptive-Offset Min-Sum Check Node Processor

This block is the check-node update for a belief-propagation decoder of a regular low-density parity-check code whose check nodes all have six edges. Each input transaction carries six variable-to-check messages. The block returns six check-to-variable messages, all produced in parallel. Each outgoing message excludes the contribution of its own edge. Its sign is the parity of the other five signs. Its magnitude is the smaller of the two lowest input magnitudes, whichever does not belong to this edge, minus a correction term and floored at zero.

The correction term is not a fixed constant. It is derived per transaction from the distance between the two lowest magnitudes. A five-segment piecewise-linear approximation of ln(1+e^-|x|) gives a value, and that value is scaled by 1.25 using one shift and one add. The segment slopes are sums of powers of two, so the datapath needs only shifters, adders and comparators. A single register stage holds the result. A valid flag travels through that stage alongside the data.

Top module: `saoms_check_node`

## Requirements
- R1: Messages are 9-bit two's complement with 5 fractional bits (one LSB = 1/32). Input lane i occupies bits [9i+8:9i] of `in_msg`, and output lane i occupies the same bits of `out_msg`.
- R2: The magnitude of an input is its absolute value. The code -256 is treated as magnitude 255.
- R3: Output lane i is negative exactly when an odd number of the other five inputs have their sign bit (bit 8) set. An output of magnitude zero is the code 0.
- R4: The smallest magnitude min1 goes to the lowest-indexed lane that holds it. min2 is the smallest magnitude among the remaining five lanes, so a tie gives min1 = min2. Lane i takes min2 when it is the min1 lane, and takes min1 otherwise.
- R5: Let g = min2 - min1 in LSBs. The correction f(g) uses floor shifts. For g ≤ 28, f = 22 - (g>>2 + g>>3 + g>>5). For 28 < g ≤ 56, f = 17 - (g>>3 + g>>4 + g>>5). For 56 < g ≤ 88, f = 10 - (g>>4 + g>>5). For 88 < g ≤ 128, f = 5 - (g>>5). For g > 128, f = 0.
- R6: The offset equals f + (f>>2).
- R7: The output magnitude is the selected minimum minus the offset, replaced by 0 when the difference is negative.
- R8: When `in_valid` is high at a rising edge, `out_valid` is high after that edge and `out_msg` shows the result for the sampled inputs. When `in_valid` is low, `out_valid` drops and `out_msg` holds its previous value.
- R9: During reset `out_valid` and `out_msg` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input lanes carry a transaction this cycle |
| in_msg | input | 54 | Six packed variable-to-check messages |
| out_valid | output | 1 | Output lanes carry a result |
| out_msg | output | 54 | Six packed check-to-variable messages |

## Verification
The bench uses several input patterns, and each one exposes a different class of fault:
- An all-zero vector and a vector of equal magnitudes show whether ties pick the lowest index and make the gap zero.
- Alternating and mixed sign patterns separate a correct exclude-own-sign parity from a plain product of all six signs.
- Vectors with min1 = 0 and min2 placed on either side of 28, 56, 88 and 128 land in each correction segment and on each boundary, so a wrong threshold or a wrong slope term shows up.
- Small equal minima force the clamp to zero, and a -256 input checks magnitude saturation.
- Random vectors with narrow spreads and with full-range values cover the remaining cases.
- Idle cycles with changed data show that the outputs hold.

// File: rtl/saoms_cn_pkg.sv
package saoms_cn_pkg;
  // Correction segment chosen from the gap between the two minima
  typedef enum logic [2:0] {
    SEG_STEEP = 3'd0,
    SEG_MID   = 3'd1,
    SEG_SHALLOW = 3'd2,
    SEG_TAIL  = 3'd3,
    SEG_ZERO  = 3'd4
  } corr_seg_e;
endpackage

// File: rtl/cn_mag_sort.sv
module cn_mag_sort #(
  parameter int DEG = 6,
  parameter int W   = 9,
  localparam int MAG_W = W - 1,
  localparam int IDX_W = $clog2(DEG)
) (
  input  logic [DEG*W-1:0]     msg_flat,
  output logic [DEG*MAG_W-1:0] mag_flat,
  output logic [DEG-1:0]       neg_flags,
  output logic [MAG_W-1:0]     min1,
  output logic [MAG_W-1:0]     min2,
  output logic [IDX_W-1:0]     min1_idx
);
  // Absolute value with saturation of the most negative code
  function automatic logic [MAG_W-1:0] abs_sat(input logic [W-1:0] v);
    logic [W-1:0] n;
    n = -v;
    if (v == {1'b1, {(W-1){1'b0}}}) return {MAG_W{1'b1}};
    else if (v[W-1]) return n[MAG_W-1:0];
    else return v[MAG_W-1:0];
  endfunction

  logic [MAG_W-1:0] mag [DEG];

  for (genvar i = 0; i < DEG; i++) begin : g_lane
    assign mag[i] = abs_sat(msg_flat[i*W +: W]);
    assign mag_flat[i*MAG_W +: MAG_W] = mag[i];
    assign neg_flags[i] = msg_flat[i*W + W - 1];
  end

  // First minimum: strict compare keeps the lowest index on ties
  always_comb begin
    min1 = mag[0];
    min1_idx = '0;
    for (int i = 1; i < DEG; i++) begin
      if (mag[i] < min1) begin
        min1 = mag[i];
        min1_idx = IDX_W'(i);
      end
    end
  end

  // Second minimum: smallest of the lanes other than the first-minimum lane
  always_comb begin
    min2 = {MAG_W{1'b1}};
    for (int i = 0; i < DEG; i++) begin
      if ((IDX_W'(i) != min1_idx) && (mag[i] < min2)) min2 = mag[i];
    end
  end
endmodule

// File: rtl/cn_pwl_offset.sv
module cn_pwl_offset
  import saoms_cn_pkg::*;
#(
  parameter int MAG_W = 8,
  parameter int FRAC  = 5
) (
  input  logic [MAG_W-1:0] gap,
  output logic [MAG_W-1:0] corr,
  output logic [MAG_W-1:0] offset,
  output logic [3:0]       seg_hot
);
  // Segment boundaries (0.875, 1.75, 2.75, 4.0) and intercepts in LSB units
  localparam int TH1 = 7  << (FRAC - 3);
  localparam int TH2 = 14 << (FRAC - 3);
  localparam int TH3 = 22 << (FRAC - 3);
  localparam int TH4 = 1  << (FRAC + 2);
  localparam int B1  = 11 << (FRAC - 4);
  localparam int B2  = 17 << (FRAC - 5);
  localparam int B3  = 5  << (FRAC - 4);
  localparam int B4  = 5  << (FRAC - 5);

  function automatic corr_seg_e pick_seg(input logic [MAG_W-1:0] x);
    if (int'(x) <= TH1) return SEG_STEEP;
    else if (int'(x) <= TH2) return SEG_MID;
    else if (int'(x) <= TH3) return SEG_SHALLOW;
    else if (int'(x) <= TH4) return SEG_TAIL;
    else return SEG_ZERO;
  endfunction

  // Slopes built only from right shifts
  function automatic logic [MAG_W-1:0] seg_value(input corr_seg_e s, input logic [MAG_W-1:0] x);
    case (s)
      SEG_STEEP:   return MAG_W'(B1) - ((x >> 2) + (x >> 3) + (x >> 5));
      SEG_MID:     return MAG_W'(B2) - ((x >> 3) + (x >> 4) + (x >> 5));
      SEG_SHALLOW: return MAG_W'(B3) - ((x >> 4) + (x >> 5));
      SEG_TAIL:    return MAG_W'(B4) - (x >> 5);
      default:     return '0;
    endcase
  endfunction

  // Scale by 1.25 as value plus value/4
  function automatic logic [MAG_W-1:0] scale_5_4(input logic [MAG_W-1:0] v);
    return v + (v >> 2);
  endfunction

  corr_seg_e seg;

  always_comb begin
    seg = pick_seg(gap);
    corr = seg_value(seg, gap);
    offset = scale_5_4(corr);
    seg_hot = 4'b0000;
    if (seg != SEG_ZERO) seg_hot[seg[1:0]] = 1'b1;
  end
endmodule

// File: rtl/cn_out_lane.sv
module cn_out_lane #(
  parameter int W = 9,
  localparam int MAG_W = W - 1
) (
  input  logic             is_min_lane,
  input  logic [MAG_W-1:0] min1,
  input  logic [MAG_W-1:0] min2,
  input  logic [MAG_W-1:0] offset,
  input  logic             neg_out,
  output logic [W-1:0]     lane_msg
);
  // Saturating subtraction toward zero
  function automatic logic [MAG_W-1:0] sub_floor(input logic [MAG_W-1:0] a, input logic [MAG_W-1:0] b);
    logic [MAG_W:0] d;
    d = {1'b0, a} - {1'b0, b};
    return d[MAG_W] ? '0 : d[MAG_W-1:0];
  endfunction

  logic [MAG_W-1:0] sel_min;
  logic [MAG_W-1:0] mag;
  logic [W-1:0]     pos;

  always_comb begin
    sel_min = is_min_lane ? min2 : min1;
    mag = sub_floor(sel_min, offset);
    pos = {1'b0, mag};
    lane_msg = neg_out ? -pos : pos;
  end
endmodule

// File: rtl/saoms_check_node.sv
module saoms_check_node #(
  parameter int DEG  = 6,
  parameter int W    = 9,
  parameter int FRAC = 5,
  localparam int MAG_W = W - 1,
  localparam int IDX_W = $clog2(DEG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [DEG*W-1:0] in_msg,
  output logic             out_valid,
  output logic [DEG*W-1:0] out_msg
);
  logic [DEG*MAG_W-1:0] mag_flat;
  logic [DEG-1:0]       neg_flags;
  logic [MAG_W-1:0]     min1;
  logic [MAG_W-1:0]     min2;
  logic [IDX_W-1:0]     min1_idx;
  logic [MAG_W-1:0]     gap;
  logic [MAG_W-1:0]     corr;
  logic [MAG_W-1:0]     offset;
  logic [3:0]           seg_hot;
  logic                 sign_all;
  logic [DEG*W-1:0]     next_msg;

  cn_mag_sort #(.DEG(DEG), .W(W)) u_sort (
    .msg_flat (in_msg),
    .mag_flat (mag_flat),
    .neg_flags(neg_flags),
    .min1     (min1),
    .min2     (min2),
    .min1_idx (min1_idx)
  );

  assign gap = min2 - min1;

  cn_pwl_offset #(.MAG_W(MAG_W), .FRAC(FRAC)) u_pwl (
    .gap    (gap),
    .corr   (corr),
    .offset (offset),
    .seg_hot(seg_hot)
  );

  // Parity of all signs; removing a lane's own sign leaves the others' parity
  assign sign_all = ^neg_flags;

  for (genvar i = 0; i < DEG; i++) begin : g_out
    cn_out_lane #(.W(W)) u_lane (
      .is_min_lane(min1_idx == IDX_W'(i)),
      .min1       (min1),
      .min2       (min2),
      .offset     (offset),
      .neg_out    (sign_all ^ neg_flags[i]),
      .lane_msg   (next_msg[i*W +: W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_msg   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_msg <= next_msg;
    end
  end
endmodule

// File: rtl/saoms_cn_checker.sv
module saoms_cn_checker #(
  parameter int DEG  = 6,
  parameter int W    = 9,
  parameter int FRAC = 5,
  localparam int MAG_W = W - 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [DEG*W-1:0] out_msg,
  input logic [MAG_W-1:0] min1,
  input logic [MAG_W-1:0] min2,
  input logic [MAG_W-1:0] gap,
  input logic [MAG_W-1:0] offset,
  input logic [3:0]       seg_hot
);
  localparam int FAR = 1 << (FRAC + 2);

  logic [W-1:0] lane0;
  logic [W-1:0] lane0_mag;
  assign lane0 = out_msg[W-1:0];
  assign lane0_mag = lane0[W-1] ? -lane0 : lane0;

  assert_min_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    min1 <= min2);

  assert_far_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(gap) > FAR) |-> (offset == '0));

  assert_one_segment_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(seg_hot));

  assert_lane_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (lane0_mag <= {1'b0, $past(min2)}));

  assert_valid_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_msg));
endmodule

bind saoms_check_node saoms_cn_checker #(.DEG(DEG), .W(W), .FRAC(FRAC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .out_valid(out_valid),
  .out_msg  (out_msg),
  .min1     (min1),
  .min2     (min2),
  .gap      (gap),
  .offset   (offset),
  .seg_hot  (seg_hot)
);

// File: tb/sim_saoms_check_node.sv
`timescale 1ns/1ps
module sim_saoms_check_node;
  localparam int DEG = 6;
  localparam int W   = 9;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [DEG*W-1:0] in_msg = '0;
  logic             out_valid;
  logic [DEG*W-1:0] out_msg;

  int vectors = 0;
  int misses = 0;
  bit finished = 1'b0;

  logic [DEG*W-1:0] exp_msg = '0;
  logic             exp_valid = 1'b0;
  string            cur_tag = "R9";

  always #2 clk = ~clk;

  saoms_check_node u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_msg(in_msg), .out_valid(out_valid), .out_msg(out_msg)
  );

  // Behavioural reference written directly from the requirements
  function automatic logic [DEG*W-1:0] model(input int v [DEG]);
    int mag [DEG];
    int m1, i1, m2, x, f, off, sel, r, cnt;
    logic [DEG*W-1:0] o;
    for (int i = 0; i < DEG; i++) begin
      mag[i] = (v[i] < 0) ? -v[i] : v[i];
      if (mag[i] > 255) mag[i] = 255;
    end
    m1 = mag[0]; i1 = 0;
    for (int i = 1; i < DEG; i++) if (mag[i] < m1) begin m1 = mag[i]; i1 = i; end
    m2 = 1 << 20;
    for (int i = 0; i < DEG; i++) if (i != i1 && mag[i] < m2) m2 = mag[i];
    x = m2 - m1;
    if (x > 128) f = 0;
    else if (x > 88) f = 5 - x / 32;
    else if (x > 56) f = 10 - (x / 16 + x / 32);
    else if (x > 28) f = 17 - (x / 8 + x / 16 + x / 32);
    else f = 22 - (x / 4 + x / 8 + x / 32);
    off = f + f / 4;
    for (int i = 0; i < DEG; i++) begin
      sel = (i == i1) ? m2 : m1;
      r = sel - off;
      if (r < 0) r = 0;
      cnt = 0;
      for (int j = 0; j < DEG; j++) if (j != i && v[j] < 0) cnt++;
      if (cnt % 2 == 1) r = -r;
      o[i*W +: W] = r[W-1:0];
    end
    return o;
  endfunction

  task automatic compare();
    vectors++;
    if (out_valid !== exp_valid || out_msg !== exp_msg) begin
      misses++;
      $display("FAIL %s: valid=%0b msg=%h expected valid=%0b msg=%h",
               cur_tag, out_valid, out_msg, exp_valid, exp_msg);
    end
  endtask

  // One cycle: check the result of the previous drive, then drive anew
  task automatic step(input int v [DEG], input bit vld, input string tag);
    logic [DEG*W-1:0] packed_in;
    @(negedge clk);
    compare();
    for (int i = 0; i < DEG; i++) packed_in[i*W +: W] = v[i][W-1:0];
    in_msg = packed_in;
    in_valid = vld;
    if (vld) exp_msg = model(v);
    exp_valid = vld;
    cur_tag = tag;
  endtask

  task automatic gap_case(input int g);
    int v [DEG];
    v = '{0, g, 200, -210, 220, 230};
    step(v, 1'b1, "R5");
  endtask

  initial begin
    int v [DEG];
    repeat (3) @(negedge clk);
    compare(); // R9 reset state
    rst_n = 1'b1;

    v = '{0, 0, 0, 0, 0, 0};           step(v, 1'b1, "R3");
    v = '{40, 40, 40, 40, 40, 40};     step(v, 1'b1, "R4");
    v = '{-40, 40, -40, 40, -40, 40};  step(v, 1'b1, "R3");
    v = '{50, -51, 52, -53, 54, -55};  step(v, 1'b1, "R3");
    v = '{-256, 255, -256, 100, 90, 255}; step(v, 1'b1, "R2");
    v = '{-256, -256, -256, -256, -256, -256}; step(v, 1'b1, "R2");
    v = '{3, 3, 100, 100, 100, 100};   step(v, 1'b1, "R7");
    v = '{90, 20, 20, -70, 60, 80};    step(v, 1'b1, "R4");
    v = '{255, 254, 253, 252, 251, 10}; step(v, 1'b1, "R1");
    v = '{-1, 1, -1, 1, -1, 1};        step(v, 1'b1, "R7");
    foreach (v[i]) v[i] = 77;
    step(v, 1'b0, "R8"); // idle cycle, different data: outputs hold
    v = '{12, 0, 30, 30, 30, 30};      step(v, 1'b0, "R8");
    v = '{12, 0, 30, 30, 30, 30};      step(v, 1'b1, "R6");

    foreach (v[i]) v[i] = 0;
    for (int g = 26; g <= 31; g++) gap_case(g);
    for (int g = 54; g <= 59; g++) gap_case(g);
    for (int g = 86; g <= 91; g++) gap_case(g);
    for (int g = 126; g <= 131; g++) gap_case(g);
    gap_case(200);
    for (int g = 0; g <= 140; g += 7) gap_case(g);

    for (int n = 0; n < 300; n++) begin
      int base;
      base = $urandom_range(0, 60);
      for (int i = 0; i < DEG; i++) begin
        v[i] = base + int'($urandom_range(0, 40));
        if ($urandom_range(0, 1) == 1) v[i] = -v[i];
      end
      step(v, ($urandom_range(0, 7) != 0), "R6");
    end
    for (int n = 0; n < 300; n++) begin
      for (int i = 0; i < DEG; i++) v[i] = int'($urandom_range(0, 511)) - 256;
      step(v, 1'b1, "R1");
    end
    foreach (v[i]) v[i] = 0;
    step(v, 1'b0, "R8");
    step(v, 1'b0, "R8");

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule